// File: doc/BRIEF.md
# Hot-swap two-wire bus connect controller

This block is the digital decision logic of a buffer that joins a backplane SDA/SCL pair to the SDA/SCL pair on a plug-in card. It holds the two sides apart until joining them cannot corrupt a transfer already under way. While the supply-good flag is low it stays in lockout with the line precharge enabled. When the supply is good it watches the backplane pair for a stop condition or for a stretch of idle bus. It then waits until both card lines are released high, and only then asserts connect.

While joined, each line behaves as one wired-AND net across the buffer. An external low on either side makes the block pull the opposite side low. The line rises again only when every device on both sides has let go, so clock stretching and arbitration work across the link. Each side has its own external-drive input, so the block never reacts to its own pull-downs. A connection-sense input isolates the sides at once and forces a full requalification before the next join. An open-drain ready output is released only while the link is up and sense is low.

Top module: `hsbus_link_ctrl`

## Requirements
- R1: From reset, and whenever the synchronized supply-good is low, connect_o is 0, precharge_o is 1, ready_pd_o is 1 and all four pull-down enables are 0. Bus activity in this state never leads to a connection.
- R2: Every input passes a two-flop synchronizer. An input change set up before clock edge n reaches the outputs no earlier than just after edge n+1. A pull-down enable follows the opposite side's synchronized level at that point, with no further register.
- R3: During qualification, a stop condition advances the block to the card check. A stop is backplane SDA sampled low and then high while backplane SCL is high in both samples. It takes effect without waiting for the idle timeout.
- R4: During qualification, IDLE_CYCLES consecutive synchronized samples with both backplane lines high also advance to the card check. Any low on either backplane line restarts the count.
- R5: connect_o rises only after both synchronized card lines are high. If either backplane line goes low before that, qualification restarts.
- R6: precharge_o is the exact inverse of connect_o in every cycle.
- R7: While connected, bp_X_pd_o = NOT cd_X_i and cd_X_pd_o = NOT bp_X_i for X in {sda, scl}, using synchronized inputs. A line therefore stays low until both sides release it, and SDA and SCL are independent.
- R8: In the cycle the synchronized sense input is high, connect_o and all pull-downs are 0 and ready_pd_o is 1. No qualification progresses while sense is high. When sense returns low, the full stop-or-idle plus card-high sequence is needed again. If sense rises in the same cycle the card check would pass, sense wins.
- R9: ready_pd_o is 0 (ready released) only while connect_o is 1, which requires sense low and supply good.
- R10: Losing supply-good in any state returns the block to lockout on the next clock, with connect_o 0 and ready_pd_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag, 1 = supply adequate |
| sense_i | input | 1 | Connection sense, 1 = force isolation |
| bp_sda_i | input | 1 | Backplane SDA as driven by external devices, 1 = released |
| bp_scl_i | input | 1 | Backplane SCL as driven by external devices, 1 = released |
| cd_sda_i | input | 1 | Card SDA as driven by external devices, 1 = released |
| cd_scl_i | input | 1 | Card SCL as driven by external devices, 1 = released |
| precharge_o | output | 1 | Enable line precharge while not joined |
| connect_o | output | 1 | 1 = sides joined |
| ready_pd_o | output | 1 | Open-drain ready pull-down, 1 = pull ready low |
| bp_sda_pd_o | output | 1 | Pull-down enable on backplane SDA |
| bp_scl_pd_o | output | 1 | Pull-down enable on backplane SCL |
| cd_sda_pd_o | output | 1 | Pull-down enable on card SDA |
| cd_scl_pd_o | output | 1 | Pull-down enable on card SCL |

## Verification
Two functions can fall in the same synchronized cycle: the card-high check that would complete the join, and a rising sense that demands isolation. The bench provokes this by holding card SCL low after a stop condition. It then releases card SCL and raises sense on the same clock phase, so both reach the synchronizer output together. The result is judged by connect_o staying 0 and ready_pd_o staying 1 for many cycles afterwards. A cycle-accurate model in the bench also compares every output on every clock, including during random phases where supply and sense toggle against a busy bus.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

    // Qualification state of the link controller
    typedef enum logic [1:0] {
        ST_LOCKOUT   = 2'd0,
        ST_SEEK_BUS  = 2'd1,
        ST_SEEK_CARD = 2'd2,
        ST_JOINED    = 2'd3
    } link_state_e;

    // Number of bus lines per side (SDA, SCL)
    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_SDA  = 0;
    localparam int unsigned LINE_SCL  = 1;

    // Layout of the synchronized input vector
    localparam int unsigned IDX_SUPPLY = 0;
    localparam int unsigned IDX_SENSE  = 1;
    localparam int unsigned IDX_BP     = 2;
    localparam int unsigned IDX_CD     = IDX_BP + NUM_LINES;
    localparam int unsigned SYNC_W     = IDX_CD + NUM_LINES;

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hsbus_bus_qual.sv
module hsbus_bus_qual #(
    parameter int unsigned IDLE_CYCLES = 9500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic stop_seen_o,
    output logic idle_seen_o
);

    localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sda_prev;
        logic          scl_prev;
    } qual_t;

    qual_t qual_d, qual_q;
    logic  both_high;

    always_comb begin
        both_high   = sda_i & scl_i;
        qual_d      = qual_q;
        qual_d.sda_prev = sda_i;
        qual_d.scl_prev = scl_i;
        if (arm_i && both_high) begin
            if (qual_q.cnt != CW'(IDLE_CYCLES)) begin
                qual_d.cnt = qual_q.cnt + 1'b1;
            end
        end else begin
            qual_d.cnt = '0;
        end
        stop_seen_o = arm_i & sda_i & ~qual_q.sda_prev & scl_i & qual_q.scl_prev;
        idle_seen_o = arm_i & both_high & (qual_q.cnt == CW'(IDLE_CYCLES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '{cnt: '0, sda_prev: 1'b1, scl_prev: 1'b1};
        end else begin
            qual_q <= qual_d;
        end
    end

    // R4: any low on a backplane line empties the idle run
    p_idle_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sda_i || !scl_i) |=> (qual_q.cnt == '0));

    // R3: a stop needs SCL high across the SDA rise
    p_stop_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen_o |-> ($past(scl_i) && scl_i && !$past(sda_i)));

endmodule

// File: rtl/hsbus_line_mirror.sv
module hsbus_line_mirror (
    input  logic active_i,
    input  logic bp_ext_i,
    input  logic cd_ext_i,
    output logic bp_pd_o,
    output logic cd_pd_o
);

    // Each side is pulled only by lows that originate on the other side
    always_comb begin
        bp_pd_o = active_i & ~cd_ext_i;
        cd_pd_o = active_i & ~bp_ext_i;
    end

endmodule

// File: rtl/hsbus_link_ctrl.sv
module hsbus_link_ctrl
    import hsbus_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 9500,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic sense_i,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    output logic precharge_o,
    output logic connect_o,
    output logic ready_pd_o,
    output logic bp_sda_pd_o,
    output logic bp_scl_pd_o,
    output logic cd_sda_pd_o,
    output logic cd_scl_pd_o
);

    typedef struct packed {
        link_state_e st;
    } ctl_t;

    logic [SYNC_W-1:0]    raw_vec;
    logic [SYNC_W-1:0]    syn_vec;
    logic [NUM_LINES-1:0] bp_ext, cd_ext, bp_pd, cd_pd;
    logic                 s_supply, s_sense;
    logic                 arm, stop_seen, idle_seen, link_active;
    ctl_t                 ctl_d, ctl_q;

    always_comb begin
        raw_vec                      = '0;
        raw_vec[IDX_SUPPLY]          = supply_ok_i;
        raw_vec[IDX_SENSE]           = sense_i;
        raw_vec[IDX_BP + LINE_SDA]   = bp_sda_i;
        raw_vec[IDX_BP + LINE_SCL]   = bp_scl_i;
        raw_vec[IDX_CD + LINE_SDA]   = cd_sda_i;
        raw_vec[IDX_CD + LINE_SCL]   = cd_scl_i;
    end

    hsbus_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (syn_vec)
    );

    assign s_supply = syn_vec[IDX_SUPPLY];
    assign s_sense  = syn_vec[IDX_SENSE];
    assign bp_ext   = syn_vec[IDX_BP +: NUM_LINES];
    assign cd_ext   = syn_vec[IDX_CD +: NUM_LINES];

    assign arm = (ctl_q.st == ST_SEEK_BUS) & s_supply & ~s_sense;

    hsbus_bus_qual #(.IDLE_CYCLES(IDLE_CYCLES)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .sda_i       (bp_ext[LINE_SDA]),
        .scl_i       (bp_ext[LINE_SCL]),
        .stop_seen_o (stop_seen),
        .idle_seen_o (idle_seen)
    );

    // Next-state decision; supply loss overrides every state
    always_comb begin
        ctl_d = ctl_q;
        if (!s_supply) begin
            ctl_d.st = ST_LOCKOUT;
        end else begin
            unique case (ctl_q.st)
                ST_LOCKOUT: ctl_d.st = ST_SEEK_BUS;
                ST_SEEK_BUS: begin
                    if (stop_seen || idle_seen) ctl_d.st = ST_SEEK_CARD;
                end
                ST_SEEK_CARD: begin
                    if (s_sense) begin
                        ctl_d.st = ST_SEEK_BUS;
                    end else if (!(&bp_ext)) begin
                        ctl_d.st = ST_SEEK_BUS;
                    end else if (&cd_ext) begin
                        ctl_d.st = ST_JOINED;
                    end
                end
                ST_JOINED: begin
                    if (s_sense) ctl_d.st = ST_SEEK_BUS;
                end
                default: ctl_d.st = ST_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_LOCKOUT};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Isolation by sense or supply acts in the same cycle it is seen
    assign link_active = (ctl_q.st == ST_JOINED) & s_supply & ~s_sense;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        hsbus_line_mirror u_mirror (
            .active_i (link_active),
            .bp_ext_i (bp_ext[g]),
            .cd_ext_i (cd_ext[g]),
            .bp_pd_o  (bp_pd[g]),
            .cd_pd_o  (cd_pd[g])
        );
    end

    assign connect_o   = link_active;
    assign precharge_o = ~link_active;
    assign ready_pd_o  = ~link_active;
    assign bp_sda_pd_o = bp_pd[LINE_SDA];
    assign bp_scl_pd_o = bp_pd[LINE_SCL];
    assign cd_sda_pd_o = cd_pd[LINE_SDA];
    assign cd_scl_pd_o = cd_pd[LINE_SCL];

    // R5: a join starts only from a card check with both card lines high
    p_join_card_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect_o) |-> ($past(&cd_ext) && $past(ctl_q.st == ST_SEEK_CARD)));

    // R3: the card check is entered only on a stop or idle event
    p_card_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEEK_CARD && $past(ctl_q.st) == ST_SEEK_BUS)
            |-> $past(stop_seen || idle_seen));

    // R7: mirror pull-downs appear only while the FSM is joined
    p_pd_only_joined_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|{bp_pd, cd_pd}) |-> (ctl_q.st == ST_JOINED && connect_o));

    // R8: sense leaves the joined state on the next clock
    p_sense_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_sense |=> (ctl_q.st != ST_JOINED));

    // R10: supply loss returns to lockout on the next clock
    p_supply_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_supply |=> (ctl_q.st == ST_LOCKOUT));

    // R9: ready released implies the link is joined
    p_ready_joined_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_pd_o |-> (ctl_q.st == ST_JOINED));

endmodule

// File: tb/hsbus_link_ctrl_bench.sv
module hsbus_link_ctrl_bench;

    localparam int IDLE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply = 1'b0, sense = 1'b0;
    logic bsda = 1'b1, bscl = 1'b1, csda = 1'b1, cscl = 1'b1;
    logic precharge, connect, ready_pd;
    logic bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hsbus_link_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_hsbus_link_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply), .sense_i(sense),
        .bp_sda_i(bsda), .bp_scl_i(bscl), .cd_sda_i(csda), .cd_scl_i(cscl),
        .precharge_o(precharge), .connect_o(connect), .ready_pd_o(ready_pd),
        .bp_sda_pd_o(bp_sda_pd), .bp_scl_pd_o(bp_scl_pd),
        .cd_sda_pd_o(cd_sda_pd), .cd_scl_pd_o(cd_scl_pd)
    );

    // ---------------- behavioural reference model ----------------
    // States: 0 lockout, 1 waiting for stop/idle, 2 waiting for card high, 3 joined
    logic [5:0] hist[$];
    int  mst;
    int  run;
    bit  pb_sda, pb_scl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {};
            hist.push_back(6'b0);
            hist.push_back(6'b0);
            mst = 0; run = 0; pb_sda = 1'b1; pb_scl = 1'b1;
        end else begin
            logic [5:0] s;
            bit armed, stop, idle;
            int nst;
            s = hist[1];
            armed = (mst == 1) && s[0] && !s[1];
            stop  = armed && s[2] && !pb_sda && s[3] && pb_scl;
            if (armed && s[2] && s[3]) run++; else run = 0;
            idle  = armed && (run == IDLE);
            nst = mst;
            if (!s[0]) nst = 0;
            else if (mst == 0) nst = 1;
            else if (mst == 1) begin
                if (stop || idle) nst = 2;
            end else if (mst == 2) begin
                if (s[1] || !(s[2] && s[3])) nst = 1;
                else if (s[4] && s[5]) nst = 3;
            end else if (s[1]) nst = 1;
            if (nst != 1) run = 0;
            mst = nst;
            pb_sda = s[2]; pb_scl = s[3];
            hist.push_front({cscl, csda, bscl, bsda, sense, supply});
            void'(hist.pop_back());
        end
    end

    task automatic report(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [5:0] s;
            bit act;
            logic [6:0] exp_v, got_v;
            s = hist[1];
            act = (mst == 3) && s[0] && !s[1];
            exp_v = {act, !act, !act, act && !s[4], act && !s[5], act && !s[2], act && !s[3]};
            got_v = {connect, precharge, ready_pd, bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd};
            report(got_v == exp_v, "model R5 R6 R7 R8 R9 R10 outputs", got_v, exp_v);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_bp(logic d, logic c);
        bsda = d; bscl = c;
    endtask

    // Drive a busy backplane then a stop: SDA rises while SCL is high
    task automatic bp_stop();
        set_bp(1'b0, 1'b0); tick(2);
        set_bp(1'b0, 1'b1); tick(2);
        set_bp(1'b0, 1'b0); tick(2);
        set_bp(1'b0, 1'b1); tick(2);
        set_bp(1'b1, 1'b1);
    endtask

    initial begin
        tick(3);
        // R1: reset state
        report(!connect && precharge && ready_pd, "R1 reset outputs", {connect, precharge, ready_pd}, 3'b011);
        report({bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd} == 4'b0, "R1 reset pull-downs",
               {bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd}, 0);
        rst_n = 1'b1;

        // R1: bus activity in lockout is ignored
        for (int i = 0; i < 120; i++) begin
            bsda = 1'($urandom); bscl = 1'($urandom);
            csda = 1'($urandom); cscl = 1'($urandom);
            tick(1);
        end
        report(!connect && ready_pd, "R1 lockout ignores bus", connect, 0);
        set_bp(1'b1, 1'b1); csda = 1'b1; cscl = 1'b1;

        // R4: idle timeout with a restart
        supply = 1'b1;
        tick(20);
        report(!connect, "R4 idle run not complete", connect, 0);
        bscl = 1'b0; tick(1); bscl = 1'b1;
        tick(30);
        report(!connect, "R4 count restarted by low", connect, 0);
        tick(30);
        report(connect, "R4 idle timeout joins", connect, 1);
        report(!precharge && !ready_pd, "R6 R9 joined outputs", {precharge, ready_pd}, 0);

        // R2: synchronizer latency on mirroring
        csda = 1'b0; tick(1);
        report(!bp_sda_pd, "R2 no effect after one edge", bp_sda_pd, 0);
        tick(1);
        report(bp_sda_pd && !cd_sda_pd, "R2 R7 mirror after two edges", bp_sda_pd, 1);
        csda = 1'b1; tick(3);

        // R7: clock stretching from the card, SDA independent
        cscl = 1'b0; tick(3);
        report(bp_scl_pd && !cd_scl_pd && !bp_sda_pd, "R7 card stretch pulls backplane SCL",
               {bp_scl_pd, cd_scl_pd, bp_sda_pd}, 3'b100);
        cscl = 1'b1; tick(3);
        report(!bp_scl_pd, "R7 SCL released", bp_scl_pd, 0);
        // R7: wired-AND arbitration across the link
        bsda = 1'b0; csda = 1'b0; tick(3);
        csda = 1'b1; tick(3);
        report(cd_sda_pd && (bsda & ~bp_sda_pd) == 1'b0, "R7 card line held by backplane low",
               cd_sda_pd, 1);
        bsda = 1'b1; tick(3);
        report((bsda & ~bp_sda_pd) && (csda & ~cd_sda_pd), "R7 both lines rise after release",
               {bp_sda_pd, cd_sda_pd}, 0);

        // R8: sense isolates at once, and qualification is held off
        sense = 1'b1; tick(2);
        report(!connect && ready_pd && !bp_sda_pd, "R8 sense isolates", connect, 0);
        tick(IDLE + 20);
        report(!connect, "R8 no join while sense high", connect, 0);

        // R3: requalify by a stop condition after sense falls
        set_bp(1'b0, 1'b0); tick(2);
        sense = 1'b0; tick(2);
        bp_stop(); tick(8);
        report(connect, "R3 stop joins before idle timeout", connect, 1);

        // R5: card held low blocks the join
        sense = 1'b1; tick(4); set_bp(1'b0, 1'b0); sense = 1'b0; cscl = 1'b0; tick(3);
        bp_stop(); tick(10);
        report(!connect, "R5 card low blocks join", connect, 0);
        cscl = 1'b1; tick(5);
        report(connect, "R5 card released joins", connect, 1);

        // R5: backplane activity before card release restarts qualification
        sense = 1'b1; tick(4); set_bp(1'b0, 1'b0); sense = 1'b0; cscl = 1'b0; tick(3);
        bp_stop(); tick(6);
        bsda = 1'b0; tick(4);
        cscl = 1'b1; tick(10);
        report(!connect, "R5 restart after backplane start", connect, 0);
        bp_stop(); tick(8);
        report(connect, "R5 join after second stop", connect, 1);

        // R8: sense and card release in the same cycle - sense wins
        sense = 1'b1; tick(4); set_bp(1'b0, 1'b0); sense = 1'b0; cscl = 1'b0; tick(3);
        bp_stop(); tick(8);
        sense = 1'b1; cscl = 1'b1; tick(15);
        report(!connect && ready_pd, "R8 sense beats card check", connect, 0);
        sense = 1'b0; tick(IDLE + 10);
        report(connect, "R4 idle rejoin after sense", connect, 1);

        // R10: supply loss while joined
        supply = 1'b0; tick(2);
        report(!connect && ready_pd && precharge, "R10 supply loss isolates", connect, 0);
        tick(IDLE + 10);
        report(!connect, "R10 stays in lockout", connect, 0);
        supply = 1'b1; tick(IDLE + 10);
        report(connect, "R10 recovery after supply returns", connect, 1);

        // Random phase against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            bsda = (r < 70) ? 1'b1 : 1'($urandom);
            bscl = ($urandom_range(0, 99) < 70) ? 1'b1 : 1'($urandom);
            csda = ($urandom_range(0, 99) < 80) ? 1'b1 : 1'($urandom);
            cscl = ($urandom_range(0, 99) < 80) ? 1'b1 : 1'($urandom);
            if ($urandom_range(0, 299) == 0) sense = ~sense;
            if ($urandom_range(0, 599) == 0) supply = ~supply;
            if ((i % 1000) == 0) begin
                supply = 1'b1; sense = 1'b0;
                set_bp(1'b1, 1'b1);
                tick(IDLE + 10);
            end
            tick(1);
        end
        tick(5);
        finish_run();
    end

endmodule